// File: doc/BRIEF.md
# Scanline-Approximating Interrupt Timer

This block raises a CPU interrupt after a programmed number of approximate video lines. A line is not counted from the video side. A prescaler takes three units on every enabled CPU cycle and wraps at 341, so each wrap marks about one line's worth of CPU time. Each wrap steps an 8-bit line counter. When that counter passes 0xFF, the block raises its interrupt and reloads the counter from an 8-bit reload value.

Software reaches four write-only control registers at the top of the CPU address space. Two of them hold the halves of the reload value, one nibble each. One register starts the timer: it reloads the counter, clears the prescaler, sets the run bit and stores a second bit to be used later. The fourth register is the acknowledge register, which copies that stored bit back into the run bit. A write to any of the four registers takes the interrupt line low.

Top module: `line_irq_timer`

## Requirements
- R1: After reset the irq output is low, and the reload value, line counter, prescaler, run bit and stored bit are all zero. An acknowledge write made straight after reset therefore leaves the timer stopped.
- R2: A control write hits when wr_en is high, wr_addr[15:12] is 0xF and wr_addr[11:2] is zero. wr_addr[1:0] then selects the register. Code 0 replaces the reload value's low nibble with wr_data, and code 1 replaces its high nibble with wr_data.
- R3: A hit with select code 2 sets the prescaler to 0 and loads the counter from the reload value. It also sets the run bit from wr_data[1] and stores wr_data[0] as the stored bit.
- R4: A hit with select code 3 copies the stored bit into the run bit.
- R5: While the run bit is set, each cycle with cpu_tick high adds 3 to the prescaler. When the sum is 341 or more, 341 is subtracted and the counter steps by one. The prescaler never holds a value above 340.
- R6: When a step would carry the counter past 0xFF, irq goes high on the same clock edge and the counter takes the reload value.
- R7: irq stays high until a control write hits. A hit clears it on the next edge, unless a counter overflow happens on that same edge, in which case irq stays high.
- R8: While the run bit is clear, cpu_tick has no effect: the prescaler and the counter hold their values.
- R9: A write whose address falls outside the four-register window has no effect. It leaves irq, the reload value and the run state unchanged.
- R10: If a select code 2 hit and an enabled cpu_tick fall in the same cycle, the reload wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | One pulse per CPU cycle to be counted |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 4 | Low nibble of the CPU write data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is an overflow that lands on the same edge as a control write. Overflows come only after long runs of ticks, and the ratio 3/341 moves the point where the prescaler wraps from one line to the next. The bench keeps its own model of the prescaler and the counter. It keeps ticking until the model predicts that the next tick will overflow, then makes a write in exactly that cycle. The same approach is used for two other cases: a reload that arrives just before a wrap, and a stop started by the start register that must hold the prescaler at zero.

// File: rtl/line_irq_pkg.sv
`timescale 1ns/1ps
package line_irq_pkg;

  // Register select, taken from the two low address bits
  typedef enum logic [1:0] {
    SEL_LAT_LO = 2'd0,
    SEL_LAT_HI = 2'd1,
    SEL_ARM    = 2'd2,
    SEL_ACK    = 2'd3
  } reg_sel_e;

  // Decoded control-write events, at most one register strobe high at a time
  typedef struct packed {
    logic hit;
    logic lat_lo;
    logic lat_hi;
    logic arm;
    logic ack;
  } ctrl_evt_t;

endpackage

// File: rtl/line_irq_decode.sv
`timescale 1ns/1ps
module line_irq_decode
  import line_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter logic [PAGE_W-1:0] PAGE = 4'hF
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output ctrl_evt_t         evt
);
  localparam int GAP_W = ADDR_W - PAGE_W - 2;

  logic     in_window;
  reg_sel_e sel;

  always_comb begin
    in_window  = wr_en
               && (wr_addr[ADDR_W-1 -: PAGE_W] == PAGE)
               && (wr_addr[2 +: GAP_W] == '0);
    sel        = reg_sel_e'(wr_addr[1:0]);
    evt        = '0;
    evt.hit    = in_window;
    evt.lat_lo = in_window && (sel == SEL_LAT_LO);
    evt.lat_hi = in_window && (sel == SEL_LAT_HI);
    evt.arm    = in_window && (sel == SEL_ARM);
    evt.ack    = in_window && (sel == SEL_ACK);
  end
endmodule

// File: rtl/line_irq_regs.sv
`timescale 1ns/1ps
module line_irq_regs
  import line_irq_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int CNT_W = 2 * NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_evt_t        evt,
  input  logic [NIB_W-1:0] wr_data,
  output logic [CNT_W-1:0] reload,
  output logic             run_en
);
  logic       saved_en;
  logic [1:0] nib_we;

  assign nib_we = {evt.lat_hi, evt.lat_lo};

  // One flop group per reload nibble
  for (genvar g = 0; g < 2; g++) begin : g_nib
    always_ff @(posedge clk) begin
      if (!rst_n)         reload[g*NIB_W +: NIB_W] <= '0;
      else if (nib_we[g]) reload[g*NIB_W +: NIB_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      saved_en <= 1'b0;
    end else if (evt.arm) begin
      run_en   <= wr_data[1];
      saved_en <= wr_data[0];
    end else if (evt.ack) begin
      run_en   <= saved_en;
    end
  end
endmodule

// File: rtl/line_irq_prescaler.sv
`timescale 1ns/1ps
module line_irq_prescaler #(
  parameter int STEP = 3,
  parameter int MOD  = 341,
  localparam int PRE_W = $clog2(MOD + STEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  output logic [PRE_W-1:0] pre,
  output logic             wrap
);
  // Returns {wrap, next value} for one step from cur (cur < MOD)
  function automatic logic [PRE_W:0] pre_next(input logic [PRE_W-1:0] cur);
    logic [PRE_W-1:0] sum;
    sum = cur + PRE_W'(STEP);
    if (sum >= PRE_W'(MOD)) return {1'b1, sum - PRE_W'(MOD)};
    return {1'b0, sum};
  endfunction

  logic [PRE_W:0]   nxt;
  logic [PRE_W-1:0] nxt_val;
  logic             nxt_wrap;

  assign nxt      = pre_next(pre);
  assign nxt_wrap = nxt[PRE_W];
  assign nxt_val  = nxt[PRE_W-1:0];
  assign wrap     = adv && nxt_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)     pre <= '0;
    else if (clear) pre <= '0;
    else if (adv)   pre <= nxt_val;
  end
endmodule

// File: rtl/line_irq_counter.sv
`timescale 1ns/1ps
module line_irq_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             bump,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  function automatic logic is_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  assign ovf = bump && is_top(count);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= reload;
    else if (ovf)   count <= reload;
    else if (bump)  count <= count + 1'b1;
  end
endmodule

// File: rtl/line_irq_timer.sv
`timescale 1ns/1ps
module line_irq_timer
  import line_irq_pkg::*;
#(
  parameter int PRE_STEP = 3,
  parameter int PRE_MOD  = 341,
  parameter int NIB_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter logic [PAGE_W-1:0] PAGE = 4'hF,
  localparam int CNT_W = 2 * NIB_W,
  localparam int PRE_W = $clog2(PRE_MOD + PRE_STEP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NIB_W-1:0]  wr_data,
  output logic              irq
);
  ctrl_evt_t        evt;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic [PRE_W-1:0] pre;
  logic             run_en;
  logic             adv;
  logic             wrap;
  logic             ovf;

  line_irq_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE(PAGE)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .evt    (evt)
  );

  line_irq_regs #(.NIB_W(NIB_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .wr_data(wr_data),
    .reload (reload),
    .run_en (run_en)
  );

  // A start write takes precedence over a tick in the same cycle
  assign adv = run_en && cpu_tick && !evt.arm;

  line_irq_prescaler #(.STEP(PRE_STEP), .MOD(PRE_MOD)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(evt.arm),
    .adv  (adv),
    .pre  (pre),
    .wrap (wrap)
  );

  line_irq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (evt.arm),
    .bump  (wrap),
    .reload(reload),
    .count (count),
    .ovf   (ovf)
  );

  // Overflow sets, a control write clears, overflow wins a tie
  always_ff @(posedge clk) begin
    if (!rst_n)       irq <= 1'b0;
    else if (ovf)     irq <= 1'b1;
    else if (evt.hit) irq <= 1'b0;
  end
endmodule

// File: rtl/line_irq_timer_chk.sv
`timescale 1ns/1ps
module line_irq_timer_chk #(
  parameter int PRE_W = 9,
  parameter int CNT_W = 8,
  parameter int STEP  = 3,
  parameter int MOD   = 341
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PRE_W-1:0] pre,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             run_en,
  input logic             arm,
  input logic             hit,
  input logic             adv,
  input logic             wrap,
  input logic             ovf,
  input logic             irq
);
  p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre) < MOD);

  p_pre_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wrap |=> int'(pre) == int'($past(pre)) + STEP);

  p_arm_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> pre == '0 && count == $past(reload));

  p_ovf_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq && count == $past(reload));

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ovf));

  p_write_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !ovf |=> !irq);

  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !arm |=> $stable(pre) && $stable(count));
endmodule

bind line_irq_timer line_irq_timer_chk #(
  .PRE_W(PRE_W), .CNT_W(CNT_W), .STEP(PRE_STEP), .MOD(PRE_MOD)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .pre   (pre),
  .count (count),
  .reload(reload),
  .run_en(run_en),
  .arm   (evt.arm),
  .hit   (evt.hit),
  .adv   (adv),
  .wrap  (wrap),
  .ovf   (ovf),
  .irq   (irq)
);

// File: tb/test_line_irq_timer.sv
`timescale 1ns/1ps
module test_line_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_tick;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [3:0]  wr_data;
  logic        irq;

  always #10 clk = ~clk;

  line_irq_timer i_line_irq_timer (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct { bit irq; string tag; } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  // Bench model: units accumulated, lines counted, own arithmetic
  int m_pre = 0, m_cnt = 0, m_lat = 0;
  bit m_run = 0, m_sav = 0, m_irq = 0;

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic bit next_tick_overflows();
    return m_run && ((m_pre + 3) / 341 != 0) && (m_cnt == 255);
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected irq
  task automatic step(input bit tk, input bit we, input logic [15:0] a,
                      input logic [3:0] d, input string tag);
    bit hit;
    bit ovf;
    exp_t e;
    cpu_tick = tk; wr_en = we; wr_addr = a; wr_data = d;
    hit = we && (a[15:12] == 4'hF) && (a[11:2] == 10'd0);
    ovf = 0;
    if (tk && m_run && !(hit && a[1:0] == 2'd2)) begin
      int units;
      units = m_pre + 3;
      m_pre = units % 341;
      if (units / 341 != 0) begin
        m_cnt++;
        if (m_cnt == 256) begin ovf = 1; m_cnt = m_lat; end
      end
    end
    if (hit) begin
      case (a[1:0])
        2'd0: m_lat = (m_lat & 'hF0) | int'(d);
        2'd1: m_lat = (m_lat & 'h0F) | (int'(d) << 4);
        2'd2: begin m_pre = 0; m_cnt = m_lat; m_run = d[1]; m_sav = d[0]; end
        default: m_run = m_sav;
      endcase
    end
    if (ovf) m_irq = 1;
    else if (hit) m_irq = 0;
    e.irq = m_irq; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 16'h0000, 4'h0, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] d, input string tag);
    step(0, 1, a, d, tag);
  endtask

  // Monitor: compares one queued expectation per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        mon_e = sbq.pop_front();
        check(irq, mon_e.irq, mon_e.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: irq=%0b expected run to finish", irq);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cpu_tick = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(irq, 1'b0, "R1 irq low in reset");
    rst_n = 1;
    @(negedge clk);
    check(irq, 1'b0, "R1 irq low after reset");

    // R1/R4: stored bit is zero, so acknowledge keeps the timer stopped
    wr(16'hF003, 4'h0, "R4 ack after reset");
    ticks(400, "R1 stopped after reset ack");

    // R1: reload value is zero -> 256 lines until overflow
    wr(16'hF002, 4'h2, "R3 start with zero reload");
    ticks(256 * 114 + 4, "R1 R5 R6 overflow from zero reload");

    // R2: nibble writes build 0xFF (upper data bits do not exist)
    wr(16'hF000, 4'hF, "R2 low nibble");
    wr(16'hF001, 4'hF, "R2 R7 high nibble clears irq");
    wr(16'hF002, 4'h2, "R3 start at 0xFF");
    ticks(113, "R5 no wrap before 114 ticks");
    ticks(1, "R6 first wrap overflows 0xFF");
    ticks(5, "R7 irq sticky without writes");

    // R9: writes outside the window
    wr(16'h8003, 4'h0, "R9 write at 0x8003 ignored");
    wr(16'hF004, 4'h0, "R9 write at 0xF004 ignored");
    wr(16'hE002, 4'h0, "R9 write at 0xE002 ignored");
    step(0, 0, 16'hF001, 4'h0, "R9 address without strobe ignored");
    wr(16'hF003, 4'h0, "R7 ack clears irq");

    // R2 R6: reload 0xFD gives three lines per overflow
    wr(16'hF000, 4'hD, "R2 low nibble D");
    wr(16'hF002, 4'h3, "R3 start with saved bit");
    ticks(700, "R6 repeated overflow with reload 0xFD");

    // R8 R4: start stopped with saved bit set, ticks ignored, ack resumes at zero
    wr(16'hF000, 4'hF, "R2 low nibble F");
    wr(16'hF002, 4'h1, "R3 start stopped");
    ticks(500, "R8 ticks ignored while stopped");
    wr(16'hF003, 4'h0, "R4 ack restores run bit");
    ticks(113, "R8 prescaler held at zero");
    ticks(1, "R4 R8 overflow timed from held state");

    // R10: start write coinciding with a tick
    wr(16'hF002, 4'h2, "R3 restart");
    ticks(113, "R10 before collision");
    step(1, 1, 16'hF002, 4'h2, "R10 start wins over tick");
    ticks(113, "R10 no early overflow");
    ticks(1, "R10 overflow after full line");

    // R7: overflow on the same edge as a clearing write
    wr(16'hF003, 4'h0, "R7 clear before collision");
    for (int i = 0; i < 400 && !next_tick_overflows(); i++)
      step(1, 0, 16'h0000, 4'h0, "R7 approach collision");
    step(1, 1, 16'hF000, 4'hF, "R7 overflow wins over write");
    ticks(3, "R7 irq stays after collision");

    step(0, 0, 16'h0000, 4'h0, "R7 drain");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule